// File: doc/BRIEF.md
# TDC Trigger Window Hit Filter

This block sits between the time-to-digital converter channels and the readout. It takes a stream of 32-bit time-data words and a trigger strobe that carries the trigger's coarse timestamp. In windowed mode it passes on only those hit words whose coarse time falls inside an asymmetric acceptance window around the most recent trigger. The window has one reach before the trigger and a separate reach after it, both counted in 5 ns coarse ticks. In pass-through mode every hit word goes through unfiltered.

Coarse times come from a counter that wraps, so every comparison is done modulo the counter range. The after-trigger reach has an enforced floor: a configured value below the floor is raised to it. The settings actually in force can be read back as one status word. Words that do not carry the time-data marker go through in both modes. Order is kept, and every output word is delayed by exactly one clock.

Top module: `tdc_trigwin_filter`

## Requirements
- R1: An input word is a time-data hit when bit 31 is 1. Its coarse time is bits COARSE_W-1:0 of the word. Bits 27-22 (channel), bits 21-12 (fine time) and bit 11 (edge) are never altered by the block.
- R2: When `cfg_trig_mode` is 0 (pass-through), every valid input word is forwarded.
- R3: A valid input word with bit 31 equal to 0 is forwarded in both modes.
- R4: In windowed mode (`cfg_trig_mode` = 1), a hit is accepted when (trigger coarse − hit coarse) mod 2^COARSE_W ≤ the before reach. A before reach of 0 accepts only the hit whose coarse time equals the trigger's.
- R5: In windowed mode, a hit is also accepted when (hit coarse − trigger coarse) mod 2^COARSE_W ≤ the effective after reach. All other hits are dropped.
- R6: The effective after reach is the larger of `cfg_after` and MIN_AFTER (default 15).
- R7: Configuration is registered. A change on the cfg inputs takes effect for hits presented one clock later.
- R8: `win_status` shows the active before reach in bits COARSE_W-1:0 and the effective after reach in bits 16+COARSE_W-1:16. All other bits are 0. After reset it reads before = 0 and after = MIN_AFTER.
- R9: The reference is the coarse time of the latest trigger. A hit presented in the same cycle as a trigger is judged against that new trigger. After reset and before any trigger, windowed mode drops every marked hit.
- R10: A forwarded word appears on `out_data` with `out_valid` high exactly one clock after it was presented, and it is unchanged. `out_valid` is 0 during and directly after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_trig_mode | input | 1 | 1 = windowed filtering, 0 = pass everything |
| cfg_before | input | COARSE_W | Window reach before the trigger, in coarse ticks |
| cfg_after | input | COARSE_W | Window reach after the trigger, in coarse ticks (floored) |
| trig_valid | input | 1 | Trigger strobe |
| trig_coarse | input | COARSE_W | Coarse time of the trigger |
| hit_valid | input | 1 | Input word valid |
| hit_data | input | 32 | Input word |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |
| win_status | output | 32 | Active window settings readback |

## Verification
The bench builds the block with COARSE_W = 6 and keeps MIN_AFTER at 15. This shrinks the coarse ring to 64 ticks, so every trigger/hit pair of coarse values can be swept for several window settings. The settings cover an after reach below the floor, a zero before reach, and windows whose two sides overlap around the ring. The small ring also makes the wrap-around arithmetic, the floor and the same-cycle trigger bypass all reachable in a few thousand cycles each.

// File: rtl/tdc_twf_pkg.sv
package tdc_twf_pkg;

   localparam int TWF_WORD_W   = 32;
   localparam int TWF_MARK_BIT = 31;
   localparam int TWF_AFTER_LSB = 16;

   typedef enum logic {
      TWF_PASS_ALL = 1'b0,
      TWF_WINDOWED = 1'b1
   } twf_mode_e;

   function automatic logic twf_is_hit(input logic [TWF_WORD_W-1:0] w);
      return w[TWF_MARK_BIT];
   endfunction

   function automatic logic [10:0] twf_coarse_field(input logic [TWF_WORD_W-1:0] w);
      return w[10:0];
   endfunction

endpackage

// File: rtl/tdc_twf_cfg.sv
module tdc_twf_cfg
   import tdc_twf_pkg::*;
#(
   parameter int COARSE_W  = 11,
   parameter int MIN_AFTER = 15
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_trig_mode,
   input  logic [COARSE_W-1:0]   cfg_before,
   input  logic [COARSE_W-1:0]   cfg_after,
   output twf_mode_e             mode_q,
   output logic [COARSE_W-1:0]   before_q,
   output logic [COARSE_W-1:0]   after_q,
   output logic [TWF_WORD_W-1:0] status_word
);

   localparam logic [COARSE_W-1:0] FLOOR = COARSE_W'(MIN_AFTER);

   logic [COARSE_W-1:0] after_eff;

   generate
      if (MIN_AFTER > 0) begin : g_floor
         assign after_eff = (cfg_after < FLOOR) ? FLOOR : cfg_after;
      end else begin : g_nofloor
         assign after_eff = cfg_after;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= TWF_PASS_ALL;
         before_q <= '0;
         after_q  <= FLOOR;
      end else begin
         mode_q   <= twf_mode_e'(cfg_trig_mode);
         before_q <= cfg_before;
         after_q  <= after_eff;
      end
   end

   always_comb begin
      status_word = '0;
      status_word[COARSE_W-1:0]             = before_q;
      status_word[TWF_AFTER_LSB +: COARSE_W] = after_q;
   end

endmodule

// File: rtl/tdc_twf_trig.sv
module tdc_twf_trig #(
   parameter int COARSE_W = 11
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trig_valid,
   input  logic [COARSE_W-1:0] trig_coarse,
   output logic [COARSE_W-1:0] ref_coarse,
   output logic                ref_ok
);

   logic [COARSE_W-1:0] held_q;
   logic                armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q  <= '0;
         armed_q <= 1'b0;
      end else if (trig_valid) begin
         held_q  <= trig_coarse;
         armed_q <= 1'b1;
      end
   end

   assign ref_coarse = trig_valid ? trig_coarse : held_q;
   assign ref_ok     = trig_valid | armed_q;

endmodule

// File: rtl/tdc_twf_cmp.sv
module tdc_twf_cmp #(
   parameter int COARSE_W = 11
)(
   input  logic [COARSE_W-1:0] hit_coarse,
   input  logic [COARSE_W-1:0] ref_coarse,
   input  logic [COARSE_W-1:0] reach_before,
   input  logic [COARSE_W-1:0] reach_after,
   output logic                in_window
);

   logic [COARSE_W-1:0] lag;
   logic [COARSE_W-1:0] lead;

   always_comb begin
      lag       = ref_coarse - hit_coarse;
      lead      = hit_coarse - ref_coarse;
      in_window = (lag <= reach_before) || (lead <= reach_after);
   end

endmodule

// File: rtl/tdc_trigwin_filter.sv
module tdc_trigwin_filter
   import tdc_twf_pkg::*;
#(
   parameter int COARSE_W  = 11,
   parameter int MIN_AFTER = 15
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_trig_mode,
   input  logic [COARSE_W-1:0] cfg_before,
   input  logic [COARSE_W-1:0] cfg_after,
   input  logic                trig_valid,
   input  logic [COARSE_W-1:0] trig_coarse,
   input  logic                hit_valid,
   input  logic [31:0]         hit_data,
   output logic                out_valid,
   output logic [31:0]         out_data,
   output logic [31:0]         win_status
);

   generate
      if (COARSE_W < 2 || COARSE_W > 11) begin : g_bad_width
         $error("tdc_trigwin_filter: COARSE_W must lie in 2..11");
      end
      if (MIN_AFTER < 0 || MIN_AFTER >= (1 << COARSE_W)) begin : g_bad_floor
         $error("tdc_trigwin_filter: MIN_AFTER must fit the coarse range");
      end
   endgenerate

   twf_mode_e           mode_q;
   logic [COARSE_W-1:0] before_q;
   logic [COARSE_W-1:0] after_q;
   logic [COARSE_W-1:0] ref_coarse;
   logic                ref_ok;
   logic                in_window;
   logic [COARSE_W-1:0] hit_coarse;
   logic                keep;

   tdc_twf_cfg #(.COARSE_W(COARSE_W), .MIN_AFTER(MIN_AFTER)) cfg_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_trig_mode (cfg_trig_mode),
      .cfg_before    (cfg_before),
      .cfg_after     (cfg_after),
      .mode_q        (mode_q),
      .before_q      (before_q),
      .after_q       (after_q),
      .status_word   (win_status)
   );

   tdc_twf_trig #(.COARSE_W(COARSE_W)) trig_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_valid  (trig_valid),
      .trig_coarse (trig_coarse),
      .ref_coarse  (ref_coarse),
      .ref_ok      (ref_ok)
   );

   assign hit_coarse = COARSE_W'(twf_coarse_field(hit_data));

   tdc_twf_cmp #(.COARSE_W(COARSE_W)) cmp_i (
      .hit_coarse   (hit_coarse),
      .ref_coarse   (ref_coarse),
      .reach_before (before_q),
      .reach_after  (after_q),
      .in_window    (in_window)
   );

   always_comb begin
      keep = 1'b0;
      if (hit_valid) begin
         if (!twf_is_hit(hit_data) || mode_q == TWF_PASS_ALL)
            keep = 1'b1;
         else
            keep = ref_ok && in_window;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= keep;
         if (keep) out_data <= hit_data;
      end
   end

endmodule

// File: rtl/tdc_twf_chk.sv
module tdc_twf_chk #(
   parameter int COARSE_W  = 11,
   parameter int MIN_AFTER = 15
)(
   input logic                clk,
   input logic                rst_n,
   input logic                mode_bit,
   input logic                hit_valid,
   input logic [31:0]         hit_data,
   input logic                out_valid,
   input logic [31:0]         out_data,
   input logic [31:0]         win_status
);

   localparam logic [31:0] USED_MASK =
      (32'((1 << COARSE_W) - 1)) | (32'((1 << COARSE_W) - 1) << 16);

   // R10
   no_orphan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(hit_valid));

   // R10
   data_unchanged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_data == $past(hit_data));

   // R3
   unmarked_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid && !hit_data[31]) |=> out_valid);

   // R2
   passall_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid && !mode_bit) |=> out_valid);

   // R6
   after_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_status[16 +: COARSE_W] >= COARSE_W'(MIN_AFTER));

   // R8
   status_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_status & ~USED_MASK) == 32'd0);

endmodule

bind tdc_trigwin_filter tdc_twf_chk #(.COARSE_W(COARSE_W), .MIN_AFTER(MIN_AFTER)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_bit   (mode_q),
   .hit_valid  (hit_valid),
   .hit_data   (hit_data),
   .out_valid  (out_valid),
   .out_data   (out_data),
   .win_status (win_status)
);

// File: tb/tdc_trigwin_filter_tb.sv
module tdc_trigwin_filter_tb_top;

   localparam int CW    = 6;
   localparam int FLOOR = 15;
   localparam int RING  = 1 << CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_trig_mode = 1'b0;
   logic [CW-1:0] cfg_before = '0;
   logic [CW-1:0] cfg_after = '0;
   logic          trig_valid = 1'b0;
   logic [CW-1:0] trig_coarse = '0;
   logic          hit_valid = 1'b0;
   logic [31:0]   hit_data = '0;
   logic          out_valid;
   logic [31:0]   out_data;
   logic [31:0]   win_status;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   tdc_trigwin_filter #(.COARSE_W(CW), .MIN_AFTER(FLOOR)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_trig_mode(cfg_trig_mode),
      .cfg_before(cfg_before), .cfg_after(cfg_after),
      .trig_valid(trig_valid), .trig_coarse(trig_coarse),
      .hit_valid(hit_valid), .hit_data(hit_data),
      .out_valid(out_valid), .out_data(out_data), .win_status(win_status)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_hit(input int h, input bit marked);
      logic [5:0]  ch = 6'(h + 1);
      logic [9:0]  fine = 10'(h * 7 + 3);
      return {marked, 3'b000, ch, fine, 1'(h), 11'(h)};
   endfunction

   function automatic bit expect_keep(input int t, input int h, input int b,
                                      input int a_raw);
      int a  = (a_raw < FLOOR) ? FLOOR : a_raw;
      int lag  = (t - h + RING) % RING;
      int lead = (h - t + RING) % RING;
      return (lag <= b) || (lead <= a);
   endfunction

   task automatic send(input bit tv, input int tc, input bit hv,
                       input logic [31:0] hd, input bit exp_v, input string req);
      @(negedge clk);
      trig_valid  = tv;
      trig_coarse = CW'(tc);
      hit_valid   = hv;
      hit_data    = hd;
      @(negedge clk);
      check(out_valid == exp_v, req, "out_valid", out_valid, exp_v);
      if (exp_v) check(out_data == hd, "R10", "out_data", out_data, hd);
      trig_valid = 1'b0;
      hit_valid  = 1'b0;
   endtask

   task automatic set_cfg(input bit m, input int b, input int a);
      @(negedge clk);
      cfg_trig_mode = m;
      cfg_before    = CW'(b);
      cfg_after     = CW'(a);
      @(negedge clk);
   endtask

   task automatic sweep(input int b, input int a);
      set_cfg(1'b1, b, a);
      for (int t = 0; t < RING; t++) begin
         send(1'b1, t, 1'b0, 32'd0, 1'b0, "R9");
         for (int h = 0; h < RING; h++)
            send(1'b0, 0, 1'b1, mk_hit(h, 1'b1), expect_keep(t, h, b, a), "R4_R5");
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
      check(win_status == (32'(FLOOR) << 16), "R8", "status in reset",
            win_status, 32'(FLOOR) << 16);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      do_reset();

      // R9: windowed mode, no trigger since reset -> marked hit dropped
      set_cfg(1'b1, 63, 63);
      send(1'b0, 0, 1'b1, mk_hit(5, 1'b1), 1'b0, "R9");
      // R3: unmarked word passes even with no trigger
      send(1'b0, 0, 1'b1, mk_hit(5, 1'b0), 1'b1, "R3");

      // R6 / R8: floor and status readback
      set_cfg(1'b1, 9, 7);
      check(win_status == ((32'(FLOOR) << 16) | 32'd9), "R6",
            "floored status", win_status, (32'(FLOOR) << 16) | 32'd9);
      set_cfg(1'b1, 3, 40);
      check(win_status == ((32'd40 << 16) | 32'd3), "R8",
            "status", win_status, (32'd40 << 16) | 32'd3);

      // R4, R5, R6, R1: exhaustive trigger/hit sweeps
      sweep(5, 3);
      sweep(0, 20);
      sweep(40, 30);
      sweep(63, 0);

      // R9: same-cycle trigger is used as the reference
      set_cfg(1'b1, 0, 20);
      send(1'b1, 50, 1'b0, 32'd0, 1'b0, "R9");
      send(1'b0, 0, 1'b1, mk_hit(30, 1'b1), 1'b0, "R9");
      send(1'b1, 10, 1'b1, mk_hit(30, 1'b1), 1'b1, "R9");
      send(1'b0, 0, 1'b1, mk_hit(31, 1'b1), 1'b0, "R9");

      // R7: mode change takes effect one clock after the cfg input changes
      send(1'b0, 0, 1'b1, mk_hit(60, 1'b1), 1'b0, "R7");
      set_cfg(1'b0, 0, 20);
      // R2: pass-through forwards out-of-window hits
      for (int h = 0; h < RING; h++)
         send(1'b0, 0, 1'b1, mk_hit(h, 1'b1), 1'b1, "R2");
      // R3: unmarked words in windowed mode
      set_cfg(1'b1, 0, 20);
      send(1'b0, 0, 1'b1, mk_hit(45, 1'b0), 1'b1, "R3");
      send(1'b0, 0, 1'b1, mk_hit(45, 1'b1), 1'b0, "R1");

      // R10: back-to-back words, order and latency
      @(negedge clk);
      hit_valid = 1'b1;
      hit_data  = mk_hit(12, 1'b0);
      @(negedge clk);
      check(out_valid && out_data == mk_hit(12, 1'b0), "R10", "first of pair",
            out_data, mk_hit(12, 1'b0));
      hit_data = mk_hit(13, 1'b0);
      @(negedge clk);
      check(out_valid && out_data == mk_hit(13, 1'b0), "R10", "second of pair",
            out_data, mk_hit(13, 1'b0));
      hit_valid = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0, "R10", "idle after pair", out_valid, 0);

      // R9: reset clears the trigger reference
      do_reset();
      set_cfg(1'b1, 63, 63);
      send(1'b0, 0, 1'b1, mk_hit(0, 1'b1), 1'b0, "R9");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule